// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block is the receive half of an asynchronous serial port. It watches the serial input line, oversamples it with a receive clock enable (`rxc_tick`), and divides that rate by a selectable factor of 16 or 64 to find bit centres. For each character it checks the start bit, gathers five to eight data bits least significant bit first, and optionally checks a parity bit. It then checks the stop bit and places the character in a holding register for the host to read.

A ready flag shows that a character is waiting. Three sticky error flags report overrun, parity and framing faults, and an error-reset pulse clears them. A separate break output rises when the line has stayed low through the stop bit of two characters in a row. It falls by itself as soon as the line goes high again.

Top module: `rxa_receiver`

## Requirements
- R1: While `rx_en` is low the receiver stays idle, accepts no character and leaves `rx_rdy` and every flag unchanged.
- R2: Only cycles with `rxc_tick` high advance bit timing. `fac_sel`=0 gives 16 ticks per bit and `fac_sel`=1 gives 64 ticks per bit, and each bit is sampled at its centre.
- R3: A frame is one low start bit, then 5+`len_sel` data bits least significant bit first, then one parity bit when `par_en`=1, then a stop bit. `rx_data` holds the data right-justified, with unused upper bits zero.
- R4: The start bit is sampled again half a bit after the line first reads low. If the line is high then, the event is dropped as noise and no character results.
- R5: `rx_rdy` rises when a character is loaded and falls in the cycle after a `rd_stb` pulse.
- R6: If a character completes while `rx_rdy` is still high, the new character replaces the old one and `ovr_err` is set.
- R7: With `par_en`=1, `par_err` is set when the XOR of the data bits and the parity bit is 1 for even parity (`par_odd`=0) or 0 for odd parity (`par_odd`=1). With `par_en`=0 no parity bit is expected.
- R8: `frm_err` is set when the stop bit is sampled low.
- R9: `ovr_err`, `par_err` and `frm_err` stay set across reads and clear only on an `err_rst` pulse.
- R10: `brk_det` rises when two consecutive characters end with a low stop bit and the synchronised line has not been high in between. A single such character does not raise it.
- R11: `brk_det` falls within three clock cycles after the line returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| rxc_tick | input | 1 | Oversampling clock enable |
| fac_sel | input | 1 | Rate factor: 0 = 16, 1 = 64 ticks per bit |
| len_sel | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rxd | input | 1 | Serial input line, idle high |
| rd_stb | input | 1 | Host read pulse, clears ready |
| err_rst | input | 1 | Clears the three error flags |
| rx_data | output | 8 | Holding register |
| rx_rdy | output | 1 | Character waiting |
| ovr_err | output | 1 | Overrun flag |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| brk_det | output | 1 | Break condition on the line |

## Verification
The hardest state to reach is the break condition. The line must stay low long enough for the receiver to restart on its own after a low stop bit and then finish a second all-low character. A single framing fault followed by a high line must not count. The bench holds the line low for about twelve bit times and confirms the flag is still low. It keeps the line low for a second character, confirms the flag is now high, and then releases the line to see it clear. Framing-error frames drive the low stop bit for only three quarters of a bit, so that the automatic restart sees a high line at its half-bit check and is rejected as noise.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    localparam int MIN_BITS = 5;

endpackage

// File: rtl/rxa_sync.sv
module rxa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rxa_frame.sv
module rxa_frame
    import rxa_pkg::*;
#(
    parameter int FAC_LO = 16,
    parameter int FAC_HI = 64,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic          fac_sel_i,
    input  logic [1:0]    len_sel_i,
    input  logic          par_en_i,
    input  logic          par_odd_i,
    input  logic          rx_i,
    output logic          done_o,
    output logic [DW-1:0] data_o,
    output logic          perr_o,
    output logic          ferr_o
);
    localparam int CW = $clog2(FAC_HI);
    localparam int IW = $clog2(DW) + 1;
    localparam logic [CW-1:0] LIM_LO  = CW'(FAC_LO - 1);
    localparam logic [CW-1:0] LIM_HI  = CW'(FAC_HI - 1);
    localparam logic [CW-1:0] HALF_LO = CW'(FAC_LO / 2 - 1);
    localparam logic [CW-1:0] HALF_HI = CW'(FAC_HI / 2 - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] ctr;
        logic [IW-1:0] idx;
        logic [DW-1:0] shf;
        logic          pacc;
        logic          perr;
        logic          done;
        logic [DW-1:0] dout;
        logic          dperr;
        logic          dferr;
    } fr_t;

    fr_t frm_d, frm_q;
    logic [CW-1:0] lim, half;
    logic [IW-1:0] nbits;
    logic          at_lim, at_half;

    always_comb begin
        frm_d      = frm_q;
        frm_d.done = 1'b0;
        lim     = fac_sel_i ? LIM_HI : LIM_LO;
        half    = fac_sel_i ? HALF_HI : HALF_LO;
        nbits   = IW'(MIN_BITS) + IW'(len_sel_i);
        at_lim  = (frm_q.ctr == lim);
        at_half = (frm_q.ctr == half);
        if (!en_i) begin
            frm_d.st  = ST_IDLE;
            frm_d.ctr = '0;
        end else if (tick_i) begin
            unique case (frm_q.st)
                ST_IDLE: begin
                    if (!rx_i) begin
                        frm_d.st   = ST_START;
                        frm_d.ctr  = '0;
                        frm_d.idx  = '0;
                        frm_d.shf  = '0;
                        frm_d.pacc = 1'b0;
                        frm_d.perr = 1'b0;
                    end
                end
                ST_START: begin
                    if (at_half) begin
                        frm_d.ctr = '0;
                        frm_d.st  = rx_i ? ST_IDLE : ST_DATA;
                    end else begin
                        frm_d.ctr = frm_q.ctr + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (at_lim) begin
                        frm_d.ctr  = '0;
                        frm_d.shf  = {rx_i, frm_q.shf[DW-1:1]};
                        frm_d.pacc = frm_q.pacc ^ rx_i;
                        if (frm_q.idx == nbits - 1'b1)
                            frm_d.st = par_en_i ? ST_PAR : ST_STOP;
                        else
                            frm_d.idx = frm_q.idx + 1'b1;
                    end else begin
                        frm_d.ctr = frm_q.ctr + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (at_lim) begin
                        frm_d.ctr  = '0;
                        frm_d.perr = ((frm_q.pacc ^ rx_i) != par_odd_i);
                        frm_d.st   = ST_STOP;
                    end else begin
                        frm_d.ctr = frm_q.ctr + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (at_lim) begin
                        frm_d.ctr   = '0;
                        frm_d.st    = ST_IDLE;
                        frm_d.done  = 1'b1;
                        frm_d.dout  = frm_q.shf >> (IW'(DW) - nbits);
                        frm_d.dperr = frm_q.perr;
                        frm_d.dferr = !rx_i;
                    end else begin
                        frm_d.ctr = frm_q.ctr + 1'b1;
                    end
                end
                default: frm_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frm_q <= '{st: ST_IDLE, default: '0};
        else        frm_q <= frm_d;
    end

    assign done_o = frm_q.done;
    assign data_o = frm_q.dout;
    assign perr_o = frm_q.dperr;
    assign ferr_o = frm_q.dferr;

    assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (frm_q.st == ST_IDLE));

    assert_noise_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && frm_q.st == ST_START && at_half && rx_i) |=> (frm_q.st == ST_IDLE));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_q.done |=> !frm_q.done);
endmodule

// File: rtl/rxa_flags.sv
module rxa_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic [DW-1:0] data_i,
    input  logic          perr_i,
    input  logic          ferr_i,
    input  logic          rx_i,
    input  logic          rd_i,
    input  logic          err_rst_i,
    output logic [DW-1:0] hold_o,
    output logic          rdy_o,
    output logic          oe_o,
    output logic          pe_o,
    output logic          fe_o,
    output logic          brk_o
);
    typedef struct packed {
        logic [DW-1:0] hold;
        logic          rdy;
        logic          oe;
        logic          pe;
        logic          fe;
        logic [1:0]    bcnt;
        logic          brk;
    } fl_t;

    fl_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (rd_i)      fl_d.rdy = 1'b0;
        if (err_rst_i) begin
            fl_d.oe = 1'b0;
            fl_d.pe = 1'b0;
            fl_d.fe = 1'b0;
        end
        if (done_i) begin
            fl_d.hold = data_i;
            fl_d.rdy  = 1'b1;
            if (fl_q.rdy && !rd_i) fl_d.oe = 1'b1;
            if (perr_i) fl_d.pe = 1'b1;
            if (ferr_i) fl_d.fe = 1'b1;
        end
        if (rx_i) begin
            fl_d.bcnt = 2'd0;
            fl_d.brk  = 1'b0;
        end else if (done_i && ferr_i) begin
            if (fl_q.bcnt != 2'd0) begin
                fl_d.bcnt = 2'd2;
                fl_d.brk  = 1'b1;
            end else begin
                fl_d.bcnt = 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign hold_o = fl_q.hold;
    assign rdy_o  = fl_q.rdy;
    assign oe_o   = fl_q.oe;
    assign pe_o   = fl_q.pe;
    assign fe_o   = fl_q.fe;
    assign brk_o  = fl_q.brk;

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done_i) |=> !rdy_o);

    assert_overrun_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && rdy_o && !rd_i) |=> oe_o);

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rst_i && !done_i) |=> (!oe_o && !pe_o && !fe_o));

    assert_brk_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_o) |-> $past(done_i && ferr_i));

    assert_brk_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_i |=> !brk_o);
endmodule

// File: rtl/rxa_receiver.sv
module rxa_receiver #(
    parameter int FAC_LO      = 16,
    parameter int FAC_HI      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       rxc_tick,
    input  logic       fac_sel,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rxd,
    input  logic       rd_stb,
    input  logic       err_rst,
    output logic [7:0] rx_data,
    output logic       rx_rdy,
    output logic       ovr_err,
    output logic       par_err,
    output logic       frm_err,
    output logic       brk_det
);
    localparam int DW = 8;

    logic          rx_s;
    logic          f_done, f_perr, f_ferr;
    logic [DW-1:0] f_data;

    rxa_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rxd),
        .q_o   (rx_s)
    );

    rxa_frame #(.FAC_LO(FAC_LO), .FAC_HI(FAC_HI), .DW(DW)) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (rx_en),
        .tick_i    (rxc_tick),
        .fac_sel_i (fac_sel),
        .len_sel_i (len_sel),
        .par_en_i  (par_en),
        .par_odd_i (par_odd),
        .rx_i      (rx_s),
        .done_o    (f_done),
        .data_o    (f_data),
        .perr_o    (f_perr),
        .ferr_o    (f_ferr)
    );

    rxa_flags #(.DW(DW)) i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (f_done),
        .data_i    (f_data),
        .perr_i    (f_perr),
        .ferr_i    (f_ferr),
        .rx_i      (rx_s),
        .rd_i      (rd_stb),
        .err_rst_i (err_rst),
        .hold_o    (rx_data),
        .rdy_o     (rx_rdy),
        .oe_o      (ovr_err),
        .pe_o      (par_err),
        .fe_o      (frm_err),
        .brk_o     (brk_det)
    );
endmodule

// File: tb/test_rxa_receiver.sv
`timescale 1ns/1ps
module test_rxa_receiver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       rxc_tick = 1'b0;
    logic       fac_sel = 1'b0;
    logic [1:0] len_sel = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_stb = 1'b0;
    logic       err_rst = 1'b0;
    logic [7:0] rx_data;
    logic       rx_rdy, ovr_err, par_err, frm_err, brk_det;

    int  n_run = 0;
    int  n_fail = 0;
    int  tdiv = 1;
    int  tcnt = 0;
    int  cyc = 0;
    bit  ended = 1'b0;

    rxa_receiver i_rxa_receiver (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxc_tick(rxc_tick),
        .fac_sel(fac_sel), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
        .rxd(rxd), .rd_stb(rd_stb), .err_rst(err_rst), .rx_data(rx_data),
        .rx_rdy(rx_rdy), .ovr_err(ovr_err), .par_err(par_err), .frm_err(frm_err),
        .brk_det(brk_det)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        if (tcnt >= tdiv - 1) begin tcnt = 0; rxc_tick = 1'b1; end
        else begin tcnt++; rxc_tick = 1'b0; end
    end

    initial begin
        wait (cyc > 150000);
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int bit_cycles();
        return (fac_sel ? 64 : 16) * tdiv;
    endfunction

    function automatic logic [7:0] mask_data(logic [7:0] d, logic [1:0] ls);
        return d & ((8'd1 << (5 + ls)) - 8'd1);
    endfunction

    function automatic logic good_parity(logic [7:0] d, logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic hold_bits(logic v, int nbits);
        rxd = v;
        repeat (nbits * bit_cycles()) @(negedge clk);
    endtask

    // Sends one frame using the current configuration inputs.
    task automatic send_frame(logic [7:0] d, logic pbit, logic stopv);
        int nb = 5 + len_sel;
        hold_bits(1'b0, 1);
        for (int i = 0; i < nb; i++) hold_bits(d[i], 1);
        if (par_en) hold_bits(pbit, 1);
        if (stopv) begin
            hold_bits(1'b1, 1);
        end else begin
            rxd = 1'b0;
            repeat (bit_cycles() * 3 / 4) @(negedge clk);
            rxd = 1'b1;
            repeat (bit_cycles() / 4) @(negedge clk);
        end
        hold_bits(1'b1, 2);
    endtask

    task automatic pulse_rd();
        rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic pulse_err();
        err_rst = 1'b1; @(negedge clk); err_rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset rdy", rx_rdy, 0);
        check("reset flags", {ovr_err, par_err, frm_err, brk_det}, 0);
        check("reset data", rx_data, 0);

        // R1: disabled receiver ignores a full frame
        rx_en = 1'b0;
        send_frame(8'hA5, 1'b0, 1'b1);
        check("R1 no char while disabled", rx_rdy, 0);
        check("R1 flags untouched", {ovr_err, par_err, frm_err}, 0);
        rx_en = 1'b1;

        // R3 R5: plain 8-bit frame at x16
        send_frame(8'h3C, 1'b0, 1'b1);
        check("R5 rdy set", rx_rdy, 1);
        check("R3 data 8N1", rx_data, 8'h3C);
        pulse_rd();
        check("R5 rdy cleared by read", rx_rdy, 0);

        // R2: tick only every third clock
        tdiv = 3;
        send_frame(8'hC9, 1'b0, 1'b1);
        check("R2 slow tick data", rx_data, 8'hC9);
        pulse_rd();
        tdiv = 1;

        // R2: x64 factor with 5 data bits
        fac_sel = 1'b1; len_sel = 2'd0;
        send_frame(8'hF6, 1'b0, 1'b1);
        check("R2 x64 data", rx_data, 8'h16);
        check("R3 upper bits zero", rx_data[7:5], 0);
        pulse_rd();
        fac_sel = 1'b0; len_sel = 2'd3;

        // R4: short low glitch rejected
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        hold_bits(1'b1, 12);
        check("R4 glitch gives no char", rx_rdy, 0);
        check("R4 glitch gives no flag", frm_err, 0);

        // R6 R9: overrun
        send_frame(8'h11, 1'b0, 1'b1);
        send_frame(8'h22, 1'b0, 1'b1);
        check("R6 overrun flag", ovr_err, 1);
        check("R6 newest kept", rx_data, 8'h22);
        pulse_rd();
        check("R9 overrun sticky after read", ovr_err, 1);
        pulse_err();
        check("R9 overrun cleared", ovr_err, 0);

        // R8 R10: one low stop bit is not a break
        send_frame(8'h00, 1'b0, 1'b0);
        check("R8 framing flag", frm_err, 1);
        check("R10 single low stop no break", brk_det, 0);
        pulse_rd(); pulse_err();

        // R10 R11: continuous low line
        hold_bits(1'b0, 12);
        check("R10 one char low not yet break", brk_det, 0);
        hold_bits(1'b0, 10);
        check("R10 break after two chars", brk_det, 1);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 break clears on high", brk_det, 0);
        hold_bits(1'b1, 14);
        pulse_rd(); pulse_err();

        // Random frames: R3 R7 R8 R2
        for (int k = 0; k < 30; k++) begin
            logic [7:0] d;
            logic bad_p, bad_s, pb;
            fac_sel = ($urandom % 4) == 0;
            len_sel = 2'($urandom % 4);
            par_en  = 1'($urandom % 2);
            par_odd = 1'($urandom % 2);
            d       = 8'($urandom);
            bad_p   = ($urandom % 5) == 0;
            bad_s   = ($urandom % 6) == 0;
            pb = good_parity(mask_data(d, len_sel), par_odd) ^ bad_p;
            send_frame(d, pb, !bad_s);
            check("R5 random rdy", rx_rdy, 1);
            check("R3 random data", rx_data, mask_data(d, len_sel));
            check("R7 random parity flag", par_err, par_en & bad_p);
            check("R8 random framing flag", frm_err, bad_s);
            check("R6 random no overrun", ovr_err, 0);
            pulse_rd();
            pulse_err();
            check("R9 random flags cleared", {par_err, frm_err}, 0);
        end

        ended = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule